// File: doc/BRIEF.md
# Dual Up-Counting Timer/Counter Unit

This block holds two identical up-counting channels. Each channel keeps its count in a low byte and a high byte. A 4-bit configuration word per channel sets the count width and wrap behaviour. The same word chooses what is counted: machine-cycle ticks from a divide-by-12 prescaler outside the block, or falling edges on an external count pin. A software run bit enables each channel. A hardware gate option can add the condition that a per-channel external gate pin is high.

When a channel wraps, it raises a sticky overflow flag that the interrupt logic clears with an acknowledge pulse. Software gets an overflow after N events by preloading the count with 2^width minus N. For example, F830 hex in 16-bit width gives an overflow after 2000 events.

Four widths are offered: 13 bits, 16 bits, 8 bits with automatic reload, and a split arrangement. In the split arrangement, channel 0 provides two independent 8-bit counters and channel 1 is frozen.

Top module: `tc_pair`

## Requirements
- R1: After synchronous reset, every count byte is 00, both overflow flags are clear and both configuration words are 0000.
- R2: A channel may count only when its run bit is 1 and either gate-enable (configuration bit 3) is 0 or its synchronized gate pin is 1. The gate pin passes through two flip-flops before use.
- R3: With source select (configuration bit 2) at 0, each `mc_tick` cycle is one count event. With it at 1, the count pin passes through two flip-flops and is sampled on each `mc_tick`. A falling edge between the previous sample and the current one is one event, so there is at most one event per tick.
- R4: Mode field (configuration bits 1:0) value 01 counts {high,low} as 16 bits; the wrap from FFFF to 0000 sets the channel's flag.
- R5: Mode 00 counts 13 bits made of the high byte over the low byte's bits 4:0. The low byte's bits 7:5 stay unchanged. The flag sets when all 13 bits wrap to zero.
- R6: Mode 10 counts only the low byte. On its wrap from FF, the low byte loads the high byte's value and the flag sets. The high byte is unchanged.
- R7: Mode 11 on channel 0 splits it into two counters. Its low byte follows channel 0's run, gate and source, wraps from FF to 00 and sets flag 0. Its high byte counts each `mc_tick` while channel 1's run bit is 1, and its wrap from FF sets flag 1. While channel 0 or channel 1 is in mode 11, channel 1's counts do not change except by register write.
- R8: An overflow flag stays set until its acknowledge is high on a clock edge, which clears it. A new wrap in the same cycle as the acknowledge leaves the flag set.
- R9: A write to either count byte of a channel loads the written data. Any count event of that channel in the same cycle is dropped and sets no flag.
- R10: A 16-bit preload of 65536−N raises the flag after exactly N events, with the count at 0000.
- R11: Count changes take effect on the clock edge that samples the event. Without a tick or a write, no count byte changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| mc_tick | input | 1 | one-cycle machine-cycle tick |
| ext_cnt | input | 2 | external count pin per channel (asynchronous) |
| ext_gate | input | 2 | external gate pin per channel (asynchronous) |
| run | input | 2 | software run bit per channel |
| lo_we | input | 2 | write strobe for each channel's low byte |
| hi_we | input | 2 | write strobe for each channel's high byte |
| wdata | input | 8 | write data for count bytes |
| cfg_we | input | 2 | write strobe for each channel's configuration word |
| cfg_wdata | input | 4 | configuration: [3] gate enable, [2] source select, [1:0] mode |
| ovf_ack | input | 2 | acknowledge, clears the channel's flag |
| cnt_lo | output | 2x8 | low count byte per channel |
| cnt_hi | output | 2x8 | high count byte per channel |
| ovf | output | 2 | overflow flag per channel |

## Verification
The bench targets the wrap points of every width.

- 13-bit mode: a design that let the prescale carry into low-byte bits 7:5 would corrupt those bits at the wrap.
- Auto-reload mode: a design that reloaded with zero would restart from 00 instead of the high byte's value.
- Split mode: a design that let channel 1 keep running would move channel 1's bytes, and one that routed the wrong run bit would leave the high byte still or raise the wrong flag.
- Write collision: a write landing on a count edge must win, or the written value shows up one count higher.
- External pin: a fast pin must never produce two counts in one tick.
- Acknowledge: a flag that dropped on its own before the acknowledge would show as a missing flag.

// File: rtl/tc_pkg.sv
package tc_pkg;

    localparam int TC_NCH   = 2;
    localparam int TC_CFG_W = 4;

    typedef enum logic [1:0] {
        TC_M13    = 2'b00,
        TC_M16    = 2'b01,
        TC_MAR8   = 2'b10,
        TC_MSPLIT = 2'b11
    } tc_mode_e;

    typedef struct packed {
        logic     gate_en;
        logic     ext_src;
        tc_mode_e mode;
    } tc_cfg_t;

    function automatic tc_cfg_t tc_cfg_unpack(input logic [TC_CFG_W-1:0] raw);
        tc_cfg_t c;
        c.gate_en = raw[3];
        c.ext_src = raw[2];
        c.mode    = tc_mode_e'(raw[1:0]);
        return c;
    endfunction

    function automatic logic tc_is_split(input tc_cfg_t c);
        return c.mode == TC_MSPLIT;
    endfunction

endpackage

// File: rtl/tc_pin_sync.sv
module tc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic pin,
    output logic level,
    output logic fall
);
    logic [STAGES-1:0] shreg;
    logic              prev_samp;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            prev_samp <= 1'b0;
        end else begin
            shreg <= {shreg[STAGES-2:0], pin};
            if (tick) prev_samp <= shreg[STAGES-1];
        end
    end

    assign level = shreg[STAGES-1];
    assign fall  = tick & prev_samp & ~shreg[STAGES-1];
endmodule

// File: rtl/tc_event_gen.sv
module tc_event_gen
    import tc_pkg::*;
(
    input  logic    tick,
    input  logic    run,
    input  tc_cfg_t cfg,
    input  logic    gate_lvl,
    input  logic    pin_fall,
    output logic    evt
);
    logic allowed;
    logic source;

    always_comb begin
        allowed = run & (~cfg.gate_en | gate_lvl);
        source  = cfg.ext_src ? pin_fall : 1'b1;
        evt     = tick & allowed & source;
    end
endmodule

// File: rtl/tc_count_core.sv
module tc_count_core
    import tc_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int PRESCALE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt,
    input  logic              side_evt,
    input  logic              hold,
    input  tc_mode_e          mode,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] lo,
    output logic [BYTE_W-1:0] hi,
    output logic              wrap_main,
    output logic              wrap_side
);
    localparam int CNT13_W = BYTE_W + PRESCALE_W;
    localparam int CNT16_W = 2 * BYTE_W;

    logic [BYTE_W-1:0]  nxt_lo, nxt_hi;
    logic [CNT13_W-1:0] cur13, inc13;
    logic [CNT16_W-1:0] inc16;
    logic               cancel;

    always_comb begin
        cur13     = {hi, lo[PRESCALE_W-1:0]};
        inc13     = cur13 + CNT13_W'(1);
        inc16     = {hi, lo} + CNT16_W'(1);
        cancel    = lo_we | hi_we;
        nxt_lo    = lo;
        nxt_hi    = hi;
        wrap_main = 1'b0;
        wrap_side = 1'b0;

        if (evt && !hold && !cancel) begin
            unique case (mode)
                TC_M13: begin
                    nxt_hi                 = inc13[CNT13_W-1:PRESCALE_W];
                    nxt_lo[PRESCALE_W-1:0] = inc13[PRESCALE_W-1:0];
                    wrap_main              = &cur13;
                end
                TC_M16: begin
                    {nxt_hi, nxt_lo} = inc16;
                    wrap_main        = &{hi, lo};
                end
                TC_MAR8: begin
                    wrap_main = &lo;
                    nxt_lo    = (&lo) ? hi : lo + BYTE_W'(1);
                end
                TC_MSPLIT: begin
                    wrap_main = &lo;
                    nxt_lo    = lo + BYTE_W'(1);
                end
                default: ;
            endcase
        end

        if (mode == TC_MSPLIT && side_evt && !hold && !cancel) begin
            nxt_hi    = hi + BYTE_W'(1);
            wrap_side = &hi;
        end

        if (lo_we) nxt_lo = wdata;
        if (hi_we) nxt_hi = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo <= '0;
            hi <= '0;
        end else begin
            lo <= nxt_lo;
            hi <= nxt_hi;
        end
    end
endmodule

// File: rtl/tc_pair.sv
module tc_pair
    import tc_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int PRESCALE_W  = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           mc_tick,
    input  logic [TC_NCH-1:0]              ext_cnt,
    input  logic [TC_NCH-1:0]              ext_gate,
    input  logic [TC_NCH-1:0]              run,
    input  logic [TC_NCH-1:0]              lo_we,
    input  logic [TC_NCH-1:0]              hi_we,
    input  logic [BYTE_W-1:0]              wdata,
    input  logic [TC_NCH-1:0]              cfg_we,
    input  logic [TC_CFG_W-1:0]            cfg_wdata,
    input  logic [TC_NCH-1:0]              ovf_ack,
    output logic [TC_NCH-1:0][BYTE_W-1:0]  cnt_lo,
    output logic [TC_NCH-1:0][BYTE_W-1:0]  cnt_hi,
    output logic [TC_NCH-1:0]              ovf
);
    tc_cfg_t [TC_NCH-1:0] cfg_q;
    logic    [TC_NCH-1:0] gate_lvl, pin_fall, evt, side_evt, hold;
    logic    [TC_NCH-1:0] wrap_main, wrap_side, flag_set;
    logic                 split_on;

    assign split_on = tc_is_split(cfg_q[0]);

    // Split high byte of channel 0 borrows channel 1's run bit; channel 1 freezes.
    assign side_evt[0] = mc_tick & run[1] & split_on;
    assign side_evt[1] = 1'b0;
    assign hold[0]     = 1'b0;
    assign hold[1]     = split_on | tc_is_split(cfg_q[1]);

    assign flag_set[0] = wrap_main[0] | wrap_side[1];
    assign flag_set[1] = wrap_main[1] | wrap_side[0];

    for (genvar c = 0; c < TC_NCH; c++) begin : g_ch
        logic unused_lvl;
        logic unused_fall;

        always_ff @(posedge clk) begin
            if (rst)            cfg_q[c] <= '0;
            else if (cfg_we[c]) cfg_q[c] <= tc_cfg_unpack(cfg_wdata);
        end

        tc_pin_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
            .clk(clk), .rst(rst), .tick(mc_tick), .pin(ext_cnt[c]),
            .level(unused_lvl), .fall(pin_fall[c])
        );

        tc_pin_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
            .clk(clk), .rst(rst), .tick(mc_tick), .pin(ext_gate[c]),
            .level(gate_lvl[c]), .fall(unused_fall)
        );

        tc_event_gen u_evt (
            .tick(mc_tick), .run(run[c]), .cfg(cfg_q[c]),
            .gate_lvl(gate_lvl[c]), .pin_fall(pin_fall[c]), .evt(evt[c])
        );

        tc_count_core #(.BYTE_W(BYTE_W), .PRESCALE_W(PRESCALE_W)) u_core (
            .clk(clk), .rst(rst), .evt(evt[c]), .side_evt(side_evt[c]),
            .hold(hold[c]), .mode(cfg_q[c].mode),
            .lo_we(lo_we[c]), .hi_we(hi_we[c]), .wdata(wdata),
            .lo(cnt_lo[c]), .hi(cnt_hi[c]),
            .wrap_main(wrap_main[c]), .wrap_side(wrap_side[c])
        );

        always_ff @(posedge clk) begin
            if (rst)              ovf[c] <= 1'b0;
            else if (flag_set[c]) ovf[c] <= 1'b1;
            else if (ovf_ack[c])  ovf[c] <= 1'b0;
        end
    end
endmodule

// File: rtl/tc_pair_chk.sv
module tc_pair_chk #(
    parameter int NCH    = 2,
    parameter int BYTE_W = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     mc_tick,
    input logic [NCH-1:0]           lo_we,
    input logic [NCH-1:0]           hi_we,
    input logic [BYTE_W-1:0]        wdata,
    input logic [NCH-1:0]           ovf_ack,
    input logic [NCH-1:0][BYTE_W-1:0] cnt_lo,
    input logic [NCH-1:0][BYTE_W-1:0] cnt_hi,
    input logic [NCH-1:0]           ovf,
    input logic                     split_on
);
    for (genvar c = 0; c < NCH; c++) begin : g_a
        // R8: flag is sticky until acknowledged
        a_r8_flag_holds: assert property (@(posedge clk) disable iff (rst)
            ovf[c] && !ovf_ack[c] |=> ovf[c]);
        // R9: low-byte write wins over a count event
        a_r9_lo_write_wins: assert property (@(posedge clk) disable iff (rst)
            lo_we[c] |=> cnt_lo[c] == $past(wdata));
        // R9: high-byte write wins over a count event
        a_r9_hi_write_wins: assert property (@(posedge clk) disable iff (rst)
            hi_we[c] |=> cnt_hi[c] == $past(wdata));
        // R11: no tick and no write leaves the count unchanged
        a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
            !mc_tick && !lo_we[c] && !hi_we[c] |=> $stable(cnt_lo[c]) && $stable(cnt_hi[c]));
    end

    // R7: channel 1 frozen while channel 0 runs split
    a_r7_ch1_held: assert property (@(posedge clk) disable iff (rst)
        split_on && !lo_we[1] && !hi_we[1] |=> $stable(cnt_lo[1]) && $stable(cnt_hi[1]));
endmodule

bind tc_pair tc_pair_chk #(.NCH(2), .BYTE_W(BYTE_W)) u_tc_pair_chk (
    .clk(clk), .rst(rst), .mc_tick(mc_tick), .lo_we(lo_we), .hi_we(hi_we),
    .wdata(wdata), .ovf_ack(ovf_ack), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
    .ovf(ovf), .split_on(split_on)
);

// File: tb/test_tc_pair.sv
`timescale 1ns/1ps
module test_tc_pair;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mc_tick = 1'b0;
    logic [1:0] ext_cnt = '0, ext_gate = '0, run = '0, lo_we = '0, hi_we = '0;
    logic [1:0] cfg_we = '0, ovf_ack = '0;
    logic [7:0] wdata = '0;
    logic [3:0] cfg_wdata = '0;
    logic [1:0][7:0] cnt_lo, cnt_hi;
    logic [1:0] ovf;

    always #10 clk = ~clk;

    tc_pair i_tc_pair (
        .clk(clk), .rst(rst), .mc_tick(mc_tick), .ext_cnt(ext_cnt), .ext_gate(ext_gate),
        .run(run), .lo_we(lo_we), .hi_we(hi_we), .wdata(wdata), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .ovf_ack(ovf_ack), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ovf(ovf)
    );

    int total = 0, bad = 0;
    string cur_req = "R1";
    int tick_per = 2, tph = 0, tick_cnt = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // tick source
    always @(negedge clk) begin
        if (rst || tick_per == 0) begin
            mc_tick = 1'b0; tph = 0;
        end else begin
            tph++;
            if (tph >= tick_per) begin tph = 0; mc_tick = 1'b1; end
            else mc_tick = 1'b0;
        end
    end
    always @(posedge clk) if (mc_tick) tick_cnt++;

    // ---------------- reference model ----------------
    int m_lo[2], m_hi[2], m_f[2], m_gate[2], m_ext[2], m_mode[2];
    int m_c1[2], m_c2[2], m_samp[2], m_g1[2], m_g2[2];
    int ev[2], wm[2], ws, v, split0, held1, fall, can;

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 2; c++) begin
                m_lo[c] = 0; m_hi[c] = 0; m_f[c] = 0; m_gate[c] = 0; m_ext[c] = 0;
                m_mode[c] = 0; m_c1[c] = 0; m_c2[c] = 0; m_samp[c] = 0; m_g1[c] = 0; m_g2[c] = 0;
            end
        end else begin
            split0 = (m_mode[0] == 3);
            held1  = split0 || (m_mode[1] == 3);
            ws = 0;
            for (int c = 0; c < 2; c++) begin
                fall  = mc_tick && m_samp[c] == 1 && m_c2[c] == 0;
                ev[c] = mc_tick && run[c] && (m_gate[c] == 0 || m_g2[c] == 1)
                        && (m_ext[c] == 0 || fall);
                wm[c] = 0;
                can = lo_we[c] || hi_we[c];
                if (ev[c] && !can && !(c == 1 && held1)) begin
                    case (m_mode[c])
                        0: begin
                            v = (m_hi[c] * 32 + m_lo[c] % 32 + 1) % 8192;
                            wm[c] = (v == 0);
                            m_hi[c] = v / 32;
                            m_lo[c] = (m_lo[c] / 32) * 32 + v % 32;
                        end
                        1: begin
                            v = (m_hi[c] * 256 + m_lo[c] + 1) % 65536;
                            wm[c] = (v == 0);
                            m_hi[c] = v / 256; m_lo[c] = v % 256;
                        end
                        2: begin
                            if (m_lo[c] == 255) begin m_lo[c] = m_hi[c]; wm[c] = 1; end
                            else m_lo[c] = m_lo[c] + 1;
                        end
                        default: begin
                            m_lo[c] = (m_lo[c] + 1) % 256;
                            wm[c] = (m_lo[c] == 0);
                        end
                    endcase
                end
                if (c == 0 && split0 && mc_tick && run[1] && !can) begin
                    m_hi[0] = (m_hi[0] + 1) % 256;
                    ws = (m_hi[0] == 0);
                end
                if (lo_we[c]) m_lo[c] = wdata;
                if (hi_we[c]) m_hi[c] = wdata;
            end
            for (int c = 0; c < 2; c++) begin
                if (ovf_ack[c]) m_f[c] = 0;
                if (wm[c] || (c == 1 && ws)) m_f[c] = 1;
                if (mc_tick) m_samp[c] = m_c2[c];
                m_c2[c] = m_c1[c]; m_c1[c] = ext_cnt[c];
                m_g2[c] = m_g1[c]; m_g1[c] = ext_gate[c];
                if (cfg_we[c]) begin
                    m_gate[c] = cfg_wdata[3]; m_ext[c] = cfg_wdata[2]; m_mode[c] = cfg_wdata[1:0];
                end
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            for (int c = 0; c < 2; c++) begin
                chk(cur_req, "cnt_lo", cnt_lo[c], m_lo[c]);
                chk(cur_req, "cnt_hi", cnt_hi[c], m_hi[c]);
                chk(cur_req, "ovf", ovf[c], m_f[c]);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr_lo(input int c, input int val);
        @(negedge clk); wdata = val[7:0]; lo_we[c] = 1'b1;
        @(negedge clk); lo_we[c] = 1'b0;
    endtask
    task automatic wr_hi(input int c, input int val);
        @(negedge clk); wdata = val[7:0]; hi_we[c] = 1'b1;
        @(negedge clk); hi_we[c] = 1'b0;
    endtask
    task automatic wr_cfg(input int c, input int val);
        @(negedge clk); cfg_wdata = val[3:0]; cfg_we[c] = 1'b1;
        @(negedge clk); cfg_we[c] = 1'b0;
    endtask
    task automatic ack(input int c);
        @(negedge clk); ovf_ack[c] = 1'b1;
        @(negedge clk); ovf_ack[c] = 1'b0;
    endtask
    task automatic run_ticks(input int c, input int n);
        @(negedge clk); tick_cnt = 0; run[c] = 1'b1;
        while (tick_cnt < n) @(negedge clk);
        run[c] = 1'b0;
    endtask
    task automatic finish_up;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL R11 watchdog expired");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        cur_req = "R1";
        chk("R1", "reset lo0", cnt_lo[0], 0); chk("R1", "reset hi1", cnt_hi[1], 0);
        chk("R1", "reset ovf", ovf, 0);

        // R4 R10: 16-bit, preload F830, 2000 events
        cur_req = "R10";
        wr_cfg(0, 4'b0001); wr_hi(0, 8'hF8); wr_lo(0, 8'h30);
        run_ticks(0, 1999);
        chk("R10", "no flag at N-1", ovf[0], 0);
        run_ticks(0, 1);
        chk("R4", "flag at FFFF wrap", ovf[0], 1);
        chk("R10", "count after N", {cnt_hi[0], cnt_lo[0]}, 16'h0000);

        // R8 ack clears
        cur_req = "R8";
        repeat (4) @(negedge clk);
        chk("R8", "flag sticky", ovf[0], 1);
        ack(0);
        chk("R8", "ack clears", ovf[0], 0);

        // R2 gate
        cur_req = "R2";
        wr_cfg(0, 4'b1001); wr_lo(0, 0); wr_hi(0, 0);
        run_ticks(0, 10);
        chk("R2", "gate pin low blocks", cnt_lo[0], 0);
        @(negedge clk); ext_gate[0] = 1'b1;
        repeat (4) @(negedge clk);
        run_ticks(0, 10);
        chk("R2", "gate pin high counts", cnt_lo[0], 10);
        ext_gate[0] = 1'b0;

        // R5 13-bit
        cur_req = "R5";
        wr_cfg(0, 4'b0000); wr_lo(0, 8'hFE); wr_hi(0, 8'hFF);
        run_ticks(0, 2);
        chk("R5", "13-bit lo keeps 7:5", cnt_lo[0], 8'hE0);
        chk("R5", "13-bit hi wraps", cnt_hi[0], 8'h00);
        chk("R5", "13-bit flag", ovf[0], 1);
        ack(0);

        // R6 auto-reload
        cur_req = "R6";
        wr_cfg(0, 4'b0010); wr_hi(0, 8'h80); wr_lo(0, 8'hFE);
        run_ticks(0, 2);
        chk("R6", "reload value", cnt_lo[0], 8'h80);
        chk("R6", "reload flag", ovf[0], 1);
        run_ticks(0, 1);
        chk("R6", "after reload", cnt_lo[0], 8'h81);
        chk("R6", "hi unchanged", cnt_hi[0], 8'h80);
        ack(0);

        // R7 split
        cur_req = "R7";
        wr_cfg(1, 4'b0001); wr_lo(1, 8'h55); wr_hi(1, 8'h00);
        wr_cfg(0, 4'b0011); wr_hi(0, 8'hFE); wr_lo(0, 8'h10);
        run_ticks(1, 2);
        chk("R7", "split hi wrap", cnt_hi[0], 8'h00);
        chk("R7", "flag1 from split hi", ovf[1], 1);
        chk("R7", "flag0 untouched", ovf[0], 0);
        chk("R7", "ch1 held", cnt_lo[1], 8'h55);
        chk("R7", "split lo idle", cnt_lo[0], 8'h10);
        run_ticks(0, 3);
        chk("R7", "split lo counts", cnt_lo[0], 8'h13);
        ack(1);
        wr_cfg(0, 4'b0001);
        run_ticks(1, 3);
        chk("R7", "ch1 resumes", cnt_lo[1], 8'h58);

        // R3 external count, slow pin
        cur_req = "R3";
        wr_cfg(0, 4'b0101); wr_lo(0, 0); wr_hi(0, 0);
        @(negedge clk); run[0] = 1'b1;
        for (int k = 0; k < 5; k++) begin
            ext_cnt[0] = 1'b1; repeat (8) @(negedge clk);
            ext_cnt[0] = 1'b0; repeat (8) @(negedge clk);
        end
        repeat (8) @(negedge clk);
        chk("R3", "five falling edges", cnt_lo[0], 5);
        // fast pin, slower tick: at most one per tick
        tick_per = 4;
        for (int k = 0; k < 40; k++) begin ext_cnt[0] = ~ext_cnt[0]; @(negedge clk); end
        run[0] = 1'b0; tick_per = 2;
        repeat (8) @(negedge clk);

        // R9 write vs. event, tick every cycle
        cur_req = "R9";
        tick_per = 1;
        wr_cfg(0, 4'b0001); wr_lo(0, 0);
        @(negedge clk); run[0] = 1'b1;
        repeat (5) @(negedge clk);
        wdata = 8'h40; lo_we[0] = 1'b1;
        @(negedge clk); lo_we[0] = 1'b0;
        chk("R9", "write wins", cnt_lo[0], 8'h40);
        @(negedge clk);
        chk("R11", "next event counts", cnt_lo[0], 8'h41);
        run[0] = 1'b0;
        tick_per = 2;
        repeat (6) @(negedge clk);

        finish_up();
    end
endmodule